// File: doc/BRIEF.md
# Host Command Ring Receiver

This block is the device side of a command ring that the host fills through register space. The ring has 64 slots of 32 bits. The host writes a command word into the next free slot and then writes the advanced producer index. Whenever the producer index differs from the block's consumer index and the engine is enabled, the block fetches the slot at the consumer index. It splits the word into a command code, a flags field and an index field and offers the result on a valid/ready port to the adapter's control engine. Each command is taken in ring order. After each accepted command the consumer index moves forward by one and is published on a port.

The host can read back the slots, the producer index and the consumer index. While the engine is stopped the host may load the consumer index, for example to zero it during initialisation. Once the engine runs, writes to the consumer index are ignored.

A producer write that would make the ring look empty while commands are still pending is refused, and a sticky error flag is raised.

Top module: `cmd_ring_rx`

## Requirements
- R1: After reset the consumer index and producer index are 0, cmd_valid is low and ovf_err is low.
- R2: A host write to byte address 0x700 + 4*k (k in 0..63) stores the word in slot k. A host read returns data on host_rdata in the cycle after host_re: the slot word, the producer index at 0x50C, or the consumer index at 0x62C (both zero-extended).
- R3: Commands are presented in ring order starting at the consumer index, split as cmd_code = word[31:24], cmd_flags = word[23:12] and cmd_index = word[11:0].
- R4: While cmd_valid is high and cmd_ready is low, the presented command holds steady. Each cycle with cmd_valid and cmd_ready both high advances cons_idx by exactly one, and cons_idx changes at no other time while running.
- R5: Both indices wrap from 63 to 0.
- R6: A producer write whose value equals the consumer index but differs from the current producer index is refused (the producer keeps its value) and sets ovf_err. ovf_err stays high until reset.
- R7: A host write to the consumer index is ignored while run_en is high. While run_en is low it loads the index and withdraws any presented command.
- R8: While run_en is low, no new command is presented.
- R9: cmd_valid is never high while the ring is empty (consumer equals producer).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Engine enable; high lets commands be fetched |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe |
| host_addr | input | 12 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, one cycle after host_re |
| cmd_valid | output | 1 | A command is presented |
| cmd_ready | input | 1 | Control engine takes the command |
| cmd_code | output | 8 | Command code field |
| cmd_flags | output | 12 | Command flags field |
| cmd_index | output | 12 | Command index field |
| cons_idx | output | 6 | Published consumer index |
| ovf_err | output | 1 | Sticky producer overflow error |

## Verification
The bench pushes batches of commands while holding ready low, toggling it pseudo-randomly, and holding it high. A design that drops or repeats a slot, or that reads the slot before the host's write has landed, yields field mismatches against the bench's queue.

Enough commands are pushed to carry both indices past 63. A design that mishandles the wrap stalls or presents stale slots.

The overflow case fills 63 entries and then writes a producer value equal to the consumer. A design that accepts that write loses every pending command and leaves the error flag low.

Consumer writes are tried both while running and while stopped with a command on the port. A design that honours the first write, or keeps presenting the withdrawn command after the second, fails the consumer index and order checks.

// File: rtl/cmdring_pkg.sv
`timescale 1ns/1ps
package cmdring_pkg;

  localparam int CODE_W  = 8;
  localparam int FLAGS_W = 12;
  localparam int INDEX_W = 12;
  localparam int WORD_W  = CODE_W + FLAGS_W + INDEX_W;

  // Packed order puts the code in the top byte and the index in the low bits.
  typedef struct packed {
    logic [CODE_W-1:0]  code;
    logic [FLAGS_W-1:0] flags;
    logic [INDEX_W-1:0] index;
  } cmd_t;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_SLOT,
    SEL_REG
  } rd_sel_e;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_FETCH,
    PS_HOLD
  } pop_state_e;

endpackage

// File: rtl/cmdring_host_if.sv
`timescale 1ns/1ps
module cmdring_host_if
  import cmdring_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int PTR_W     = 6,
  parameter int DEPTH     = 64,
  parameter int RING_BASE = 'h700,
  parameter int PROD_ADDR = 'h50C,
  parameter int CONS_ADDR = 'h62C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [PTR_W-1:0]  prod_q,
  input  logic [PTR_W-1:0]  cons_q,
  input  logic [WORD_W-1:0] slot_rdata,
  output logic              slot_en,
  output logic              slot_we,
  output logic [PTR_W-1:0]  slot_idx,
  output logic              prod_we,
  output logic              cons_we,
  output logic [WORD_W-1:0] host_rdata
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(RING_BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(DEPTH * 4);
  localparam logic [ADDR_W-1:0] PROD_A = ADDR_W'(PROD_ADDR);
  localparam logic [ADDR_W-1:0] CONS_A = ADDR_W'(CONS_ADDR);

  logic [ADDR_W-1:0] offset;
  logic              in_ring;
  logic              prod_hit;
  logic              cons_hit;
  rd_sel_e           sel_q;
  logic [PTR_W-1:0]  hold_q;

  always_comb begin
    offset   = host_addr - BASE_A;
    in_ring  = (host_addr >= BASE_A) && (offset < SPAN_A) && (offset[1:0] == 2'b00);
    prod_hit = (host_addr == PROD_A);
    cons_hit = (host_addr == CONS_A);
    slot_idx = offset[PTR_W+1:2];
    slot_en  = (host_we || host_re) && in_ring;
    slot_we  = host_we && in_ring;
    prod_we  = host_we && prod_hit;
    cons_we  = host_we && cons_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= SEL_NONE;
      hold_q <= '0;
    end else if (host_re) begin
      if (in_ring) begin
        sel_q <= SEL_SLOT;
      end else if (prod_hit) begin
        sel_q  <= SEL_REG;
        hold_q <= prod_q;
      end else if (cons_hit) begin
        sel_q  <= SEL_REG;
        hold_q <= cons_q;
      end else begin
        sel_q <= SEL_NONE;
      end
    end else begin
      sel_q <= SEL_NONE;
    end
  end

  always_comb begin
    case (sel_q)
      SEL_SLOT: host_rdata = slot_rdata;
      SEL_REG:  host_rdata = WORD_W'(hold_q);
      default:  host_rdata = '0;
    endcase
  end

endmodule

// File: rtl/cmdring_slots.sv
`timescale 1ns/1ps
module cmdring_slots #(
  parameter int DEPTH = 64,
  parameter int PTR_W = 6,
  parameter int W     = 32
) (
  input  logic             clk,
  input  logic             a_en,
  input  logic             a_we,
  input  logic [PTR_W-1:0] a_addr,
  input  logic [W-1:0]     a_wdata,
  output logic [W-1:0]     a_rdata,
  input  logic             b_en,
  input  logic [PTR_W-1:0] b_addr,
  output logic [W-1:0]     b_rdata
);

  logic [W-1:0] mem [DEPTH];

  // Host side: read-first write/read port
  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      a_rdata <= mem[a_addr];
    end
  end

  // Engine side: read-only port
  always_ff @(posedge clk) begin
    if (b_en) b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/cmdring_ptrs.sv
`timescale 1ns/1ps
module cmdring_ptrs #(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic             prod_we,
  input  logic             cons_we,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic             pop_done,
  output logic [PTR_W-1:0] prod_q,
  output logic [PTR_W-1:0] cons_q,
  output logic             flush,
  output logic             ovf_err
);

  logic would_overflow;

  always_comb begin
    flush          = cons_we && !run_en;
    would_overflow = (wr_idx == cons_q) && (wr_idx != prod_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q  <= '0;
      ovf_err <= 1'b0;
    end else if (prod_we) begin
      if (would_overflow) ovf_err <= 1'b1;
      else                prod_q  <= wr_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           cons_q <= '0;
    else if (flush)    cons_q <= wr_idx;
    else if (pop_done) cons_q <= cons_q + 1'b1;
  end

endmodule

// File: rtl/cmdring_pop.sv
`timescale 1ns/1ps
module cmdring_pop
  import cmdring_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic              flush,
  input  logic [PTR_W-1:0]  prod_q,
  input  logic [PTR_W-1:0]  cons_q,
  output logic              rd_en,
  output logic [PTR_W-1:0]  rd_addr,
  input  logic [WORD_W-1:0] rd_data,
  input  logic              cmd_ready,
  output logic              cmd_valid,
  output cmd_t              cmd_out,
  output logic              pop_done
);

  pop_state_e state_q;
  logic       pending;

  always_comb begin
    pending   = (cons_q != prod_q);
    rd_en     = (state_q == PS_IDLE) && run_en && pending && !flush;
    rd_addr   = cons_q;
    pop_done  = cmd_valid && cmd_ready && !flush;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= PS_IDLE;
      cmd_valid <= 1'b0;
      cmd_out   <= '0;
    end else if (flush) begin
      state_q   <= PS_IDLE;
      cmd_valid <= 1'b0;
    end else begin
      case (state_q)
        PS_IDLE: begin
          if (rd_en) state_q <= PS_FETCH;
        end
        PS_FETCH: begin
          cmd_out   <= cmd_t'(rd_data);
          cmd_valid <= 1'b1;
          state_q   <= PS_HOLD;
        end
        PS_HOLD: begin
          if (cmd_ready) begin
            cmd_valid <= 1'b0;
            state_q   <= PS_IDLE;
          end
        end
        default: state_q <= PS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cmd_ring_rx.sv
`timescale 1ns/1ps
module cmd_ring_rx
  import cmdring_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DEPTH     = 64,
  parameter int RING_BASE = 'h700,
  parameter int PROD_ADDR = 'h50C,
  parameter int CONS_ADDR = 'h62C,
  localparam int PTR_W    = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run_en,
  input  logic                host_we,
  input  logic                host_re,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [WORD_W-1:0]   host_wdata,
  output logic [WORD_W-1:0]   host_rdata,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output logic [CODE_W-1:0]   cmd_code,
  output logic [FLAGS_W-1:0]  cmd_flags,
  output logic [INDEX_W-1:0]  cmd_index,
  output logic [PTR_W-1:0]    cons_idx,
  output logic                ovf_err
);

  logic              slot_en, slot_we, prod_we, cons_we, flush, pop_done;
  logic              rd_en;
  logic [PTR_W-1:0]  slot_idx, rd_addr, prod_q, cons_q;
  logic [WORD_W-1:0] slot_rdata, rd_data;
  cmd_t              cmd_out;

  cmdring_host_if #(
    .ADDR_W(ADDR_W), .PTR_W(PTR_W), .DEPTH(DEPTH),
    .RING_BASE(RING_BASE), .PROD_ADDR(PROD_ADDR), .CONS_ADDR(CONS_ADDR)
  ) u_host (
    .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .prod_q(prod_q), .cons_q(cons_q),
    .slot_rdata(slot_rdata), .slot_en(slot_en), .slot_we(slot_we),
    .slot_idx(slot_idx), .prod_we(prod_we), .cons_we(cons_we),
    .host_rdata(host_rdata)
  );

  cmdring_slots #(.DEPTH(DEPTH), .PTR_W(PTR_W), .W(WORD_W)) u_slots (
    .clk(clk), .a_en(slot_en), .a_we(slot_we), .a_addr(slot_idx),
    .a_wdata(host_wdata), .a_rdata(slot_rdata),
    .b_en(rd_en), .b_addr(rd_addr), .b_rdata(rd_data)
  );

  cmdring_ptrs #(.PTR_W(PTR_W)) u_ptrs (
    .clk(clk), .rst(rst), .run_en(run_en), .prod_we(prod_we),
    .cons_we(cons_we), .wr_idx(host_wdata[PTR_W-1:0]), .pop_done(pop_done),
    .prod_q(prod_q), .cons_q(cons_q), .flush(flush), .ovf_err(ovf_err)
  );

  cmdring_pop #(.PTR_W(PTR_W)) u_pop (
    .clk(clk), .rst(rst), .run_en(run_en), .flush(flush),
    .prod_q(prod_q), .cons_q(cons_q), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .cmd_ready(cmd_ready), .cmd_valid(cmd_valid),
    .cmd_out(cmd_out), .pop_done(pop_done)
  );

  assign cmd_code  = cmd_out.code;
  assign cmd_flags = cmd_out.flags;
  assign cmd_index = cmd_out.index;
  assign cons_idx  = cons_q;

endmodule

// File: rtl/cmd_ring_rx_chk.sv
`timescale 1ns/1ps
module cmd_ring_rx_chk #(
  parameter int ADDR_W    = 12,
  parameter int PTR_W     = 6,
  parameter int CONS_ADDR = 'h62C
) (
  input logic              clk,
  input logic              rst,
  input logic              run_en,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [7:0]        cmd_code,
  input logic [11:0]       cmd_flags,
  input logic [11:0]       cmd_index,
  input logic [PTR_W-1:0]  cons_idx,
  input logic [PTR_W-1:0]  prod_q,
  input logic              ovf_err
);

  logic host_cons_load;
  assign host_cons_load = host_we && (host_addr == ADDR_W'(CONS_ADDR)) && !run_en;

  // R4
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready && !host_cons_load |=>
      cmd_valid && $stable(cmd_code) && $stable(cmd_flags) && $stable(cmd_index));

  // R5
  cons_step_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && !host_cons_load |=>
      cons_idx == PTR_W'($past(cons_idx) + 1'b1));

  // R7
  cons_still_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && cmd_ready) && !host_cons_load |=> $stable(cons_idx));

  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_err |=> ovf_err);

  // R9
  nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cons_idx != prod_q);

  // R8
  run_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !run_en && $past(!run_en) && !cmd_valid |=> !cmd_valid);

endmodule

bind cmd_ring_rx cmd_ring_rx_chk #(
  .ADDR_W(ADDR_W), .PTR_W(PTR_W), .CONS_ADDR(CONS_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .run_en(run_en), .host_we(host_we),
  .host_addr(host_addr), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_code(cmd_code), .cmd_flags(cmd_flags), .cmd_index(cmd_index),
  .cons_idx(cons_idx), .prod_q(prod_q), .ovf_err(ovf_err)
);

// File: tb/tb_cmd_ring_rx.sv
`timescale 1ns/1ps
module tb_cmd_ring_rx;

  localparam logic [11:0] RING_A = 12'h700;
  localparam logic [11:0] PROD_A = 12'h50C;
  localparam logic [11:0] CONS_A = 12'h62C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic        host_we = 1'b0;
  logic        host_re = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [7:0]  cmd_code;
  logic [11:0] cmd_flags;
  logic [11:0] cmd_index;
  logic [5:0]  cons_idx;
  logic        ovf_err;

  cmd_ring_rx dut (
    .clk(clk), .rst(rst), .run_en(run_en), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
    .cmd_flags(cmd_flags), .cmd_index(cmd_index), .cons_idx(cons_idx),
    .ovf_err(ovf_err)
  );

  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit mon_on = 1'b0;
  int rmode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // Reference model state
  logic [31:0] slot_mem [64];
  logic [31:0] exp_q [$];
  int model_prod = 0;
  int model_cons = 0;
  bit model_err = 1'b0;
  int total_pushed = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      finish_run();
    end
  end

  // Ready driver
  always begin
    @(posedge clk);
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rmode)
      0: cmd_ready = 1'b0;
      1: cmd_ready = 1'b1;
      default: cmd_ready = lfsr[0];
    endcase
  end

  // Cycle-by-cycle reference comparison
  always @(negedge clk) begin
    if (mon_on) begin
      bit flushed;
      flushed = 1'b0;
      chk(cons_idx == 6'(model_cons), "R4 consumer index", 32'(cons_idx), 32'(model_cons));
      chk(ovf_err == model_err, "R6 error flag", 32'(ovf_err), 32'(model_err));
      if (cmd_valid && exp_q.size() == 0)
        chk(1'b0, "R9 valid on empty ring", 32'(cmd_valid), 32'd0);
      if (host_we) begin
        if (host_addr >= RING_A && host_addr < RING_A + 12'd256) begin
          slot_mem[(host_addr - RING_A) >> 2] = host_wdata;
        end else if (host_addr == PROD_A) begin
          int v;
          v = int'(host_wdata[5:0]);
          if (v == model_cons && v != model_prod) begin
            model_err = 1'b1;
          end else begin
            for (int k = model_prod; k != v; k = (k + 1) % 64) exp_q.push_back(slot_mem[k]);
            model_prod = v;
          end
        end else if (host_addr == CONS_A && !run_en) begin
          model_cons = int'(host_wdata[5:0]);
          exp_q.delete();
          for (int k = model_cons; k != model_prod; k = (k + 1) % 64) exp_q.push_back(slot_mem[k]);
          flushed = 1'b1;
        end
      end
      if (cmd_valid && cmd_ready && !flushed) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected command", {cmd_code, cmd_flags, cmd_index}, 32'd0);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(cmd_code == e[31:24], "R3 code field", 32'(cmd_code), 32'(e[31:24]));
          chk(cmd_flags == e[23:12], "R3 flags field", 32'(cmd_flags), 32'(e[23:12]));
          chk(cmd_index == e[11:0], "R3 index field", 32'(cmd_index), 32'(e[11:0]));
        end
        model_cons = (model_cons + 1) % 64;
      end
    end
  end

  task automatic hw(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #2;
    host_we = 1'b0;
  endtask

  task automatic hr(input logic [11:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    host_re = 1'b1; host_addr = a;
    @(posedge clk); #2;
    host_re = 1'b0;
    #2 d = host_rdata;
  endtask

  task automatic set_run(input bit v);
    @(posedge clk); #2;
    run_en = v;
  endtask

  function automatic logic [31:0] mk(input int i, input int s);
    return {8'(s + i), 12'(i * 37 + s * 5), 12'(4095 - i * 3)};
  endfunction

  task automatic push(input int n, input int s);
    int p;
    p = model_prod;
    for (int i = 0; i < n; i++) hw(RING_A + 12'(4 * ((p + i) % 64)), mk(i, s));
    hw(PROD_A, 32'((p + n) % 64));
    total_pushed += n;
  endtask

  task automatic drain(input string tag);
    bit done;
    done = 1'b0;
    for (int i = 0; i < 3000 && !done; i++) begin
      @(negedge clk); #1;
      if (exp_q.size() == 0 && !cmd_valid) done = 1'b1;
    end
    chk(done, tag, 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    logic [31:0] rd;
    repeat (5) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(cons_idx == 6'd0, "R1 consumer after reset", 32'(cons_idx), 32'd0);
    chk(cmd_valid == 1'b0, "R1 valid after reset", 32'(cmd_valid), 32'd0);
    chk(ovf_err == 1'b0, "R1 error after reset", 32'(ovf_err), 32'd0);
    hr(PROD_A, rd);
    chk(rd == 32'd0, "R1 producer after reset", rd, 32'd0);
    mon_on = 1'b1;

    // Initialisation: zero all slots and both indices
    for (int k = 0; k < 64; k++) hw(RING_A + 12'(4 * k), 32'd0);
    hw(PROD_A, 32'd0);
    hw(CONS_A, 32'd0);

    // R2 slot and register readback
    hw(RING_A + 12'd20, 32'hDEAD_BEEF);
    hr(RING_A + 12'd20, rd);
    chk(rd == 32'hDEAD_BEEF, "R2 slot readback", rd, 32'hDEAD_BEEF);
    hr(CONS_A, rd);
    chk(rd == 32'd0, "R2 consumer readback", rd, 32'd0);

    // R3 basic ordered flow
    rmode = 1;
    set_run(1'b1);
    push(3, 1);
    hr(PROD_A, rd);
    chk(rd == 32'd3, "R2 producer readback", rd, 32'd3);
    drain("R3 basic drain");

    // R6 a producer rewrite of its own value is not an overflow
    hw(PROD_A, 32'(model_prod));
    repeat (2) @(negedge clk);
    chk(ovf_err == 1'b0, "R6 no false overflow", 32'(ovf_err), 32'd0);

    // R4 backpressure
    rmode = 0;
    push(5, 40);
    repeat (6) @(negedge clk);
    chk(cmd_valid == 1'b1, "R4 valid held under backpressure", 32'(cmd_valid), 32'd1);
    chk(cons_idx == 6'd3, "R4 no advance without ready", 32'(cons_idx), 32'd3);
    rmode = 2;
    drain("R4 random ready drain");

    // R5 wrap past slot 63
    push(30, 70);
    drain("R5 drain batch a");
    push(30, 110);
    drain("R5 drain batch b");
    chk(cons_idx == 6'(total_pushed % 64), "R5 consumer after wrap", 32'(cons_idx), 32'(total_pushed % 64));
    hr(PROD_A, rd);
    chk(rd == 32'(total_pushed % 64), "R5 producer after wrap", rd, 32'(total_pushed % 64));

    // R6 overflow
    rmode = 0;
    push(63, 150);
    hw(PROD_A, 32'(model_cons));
    repeat (2) @(negedge clk);
    chk(ovf_err == 1'b1, "R6 overflow flagged", 32'(ovf_err), 32'd1);
    hr(PROD_A, rd);
    chk(rd == 32'(total_pushed % 64), "R6 producer kept", rd, 32'(total_pushed % 64));
    rmode = 2;
    drain("R6 pending survive overflow");
    chk(ovf_err == 1'b1, "R6 error sticky", 32'(ovf_err), 32'd1);

    // R8 stopped engine presents nothing
    rmode = 1;
    set_run(1'b0);
    push(4, 200);
    repeat (20) @(negedge clk);
    chk(cmd_valid == 1'b0, "R8 no command while stopped", 32'(cmd_valid), 32'd0);
    chk(cons_idx == 6'(model_cons), "R8 consumer frozen", 32'(cons_idx), 32'(model_cons));
    set_run(1'b1);
    drain("R8 drain after restart");

    // R7 consumer write ignored while running
    hw(CONS_A, 32'((model_cons + 5) % 64));
    repeat (2) @(negedge clk);
    chk(cons_idx == 6'(total_pushed % 64), "R7 write ignored while running", 32'(cons_idx), 32'(total_pushed % 64));

    // R7 consumer load while stopped withdraws the presented command
    rmode = 0;
    push(6, 220);
    repeat (8) @(negedge clk);
    chk(cmd_valid == 1'b1, "R3 command presented", 32'(cmd_valid), 32'd1);
    set_run(1'b0);
    hw(CONS_A, 32'((model_cons + 2) % 64));
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R7 command withdrawn", 32'(cmd_valid), 32'd0);
    chk(cons_idx == 6'((total_pushed - 4) % 64), "R7 consumer loaded", 32'(cons_idx), 32'((total_pushed - 4) % 64));
    rmode = 1;
    set_run(1'b1);
    drain("R7 drain after skip");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule